// File: doc/BRIEF.md
# Partial-Width Register File

This block is an eight-entry bank of 32-bit integer registers with two read ports and one write port. Each port can access a register at full 32-bit width, at half-word width (bits 15:0), or at byte width. A byte access reaches bits 7:0 of any register. On the first four registers it can also reach bits 15:8. Each port carries a register index, a two-bit access-width code and a high-byte select.

Reads are combinational from the stored state, and the selected field is returned right-aligned with zeros above it. A write is applied at the rising clock edge. A narrow write merges into the destination, so every bit outside the addressed field keeps its value. A request that asks for the upper byte of a register with no upper-byte view is raised on a per-port illegal flag. So is a request that uses the reserved width code. An illegal write changes nothing, and an illegal read returns zero.

Top module: `partial_rf`

## Requirements
- R1: A synchronous, active-high reset clears every register to zero; after reset every 32-bit read returns 0.
- R2: Width code 2'b00 (32-bit) reads return all 32 bits of the indexed register, and 32-bit writes replace all 32 bits.
- R3: Width code 2'b01 (16-bit) reads return bits 15:0 in bits 15:0 with zeros above. 16-bit writes replace bits 15:0 with wr_data[15:0] and keep bits 31:16.
- R4: Width code 2'b10 (8-bit) with the high select at 0 reads bits 7:0 of any register into bits 7:0, with zeros above. A write of this kind replaces only bits 7:0 with wr_data[7:0].
- R5: Width code 2'b10 with the high select at 1 on registers 0 to 3 reads bits 15:8 into bits 7:0 of the read data, with zeros above. A write of this kind replaces only bits 15:8 with wr_data[7:0].
- R6: Width code 2'b10 with the high select at 1 on registers 4 to 7 raises the port's illegal flag. A write under this request changes no register, and a read under it returns 0.
- R7: Width code 2'b11 is reserved. It raises the port's illegal flag, suppresses the write and returns 0 on a read.
- R8: A read of the register being written in the same cycle returns its old value. The new value is visible from the cycle after the clock edge.
- R9: With wr_en low, no register changes, whatever the other write inputs carry.
- R10: The high select has no effect for widths 32 and 16. Such requests are legal and behave exactly as with the select at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| rd0_idx | input | 3 | Read port 0 register index |
| rd0_width | input | 2 | Read port 0 width code (00=32, 01=16, 10=8, 11 reserved) |
| rd0_hi | input | 1 | Read port 0 high-byte select |
| rd0_data | output | 32 | Read port 0 data, right-aligned, zero-padded |
| rd0_bad | output | 1 | Read port 0 illegal request |
| rd1_idx | input | 3 | Read port 1 register index |
| rd1_width | input | 2 | Read port 1 width code |
| rd1_hi | input | 1 | Read port 1 high-byte select |
| rd1_data | output | 32 | Read port 1 data |
| rd1_bad | output | 1 | Read port 1 illegal request |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 3 | Write register index |
| wr_width | input | 2 | Write width code |
| wr_hi | input | 1 | Write high-byte select |
| wr_data | input | 32 | Write data; narrow fields taken from the low bits |
| wr_bad | output | 1 | Write port illegal request |

## Verification
Some faults corrupt bits outside the addressed field: a merge that widens its mask, or a byte lane that is picked wrongly. Such a fault stays hidden in the register until a wider read of that register is made. The bench therefore follows narrow writes with full-width reads and compares both read ports with a behavioural model on every cycle. A suppressed illegal write that slips through, or a write that goes to the wrong index, shows at the ports only from the cycle after the edge, and only on a read of the affected register. Random traffic across all indices and widths keeps that delay short.

// File: rtl/rf_pkg.sv
package rf_pkg;
  typedef enum logic [1:0] {
    ACC_W32  = 2'b00,
    ACC_W16  = 2'b01,
    ACC_W8   = 2'b10,
    ACC_RSVD = 2'b11
  } acc_width_e;

  typedef struct packed {
    logic       legal;
    acc_width_e width;
    logic       upper;   // byte access aimed at bits 15:8
  } acc_req_t;
endpackage

// File: rtl/rf_access_decode.sv
module rf_access_decode
  import rf_pkg::*;
#(
  parameter int IDX_W   = 3,
  parameter int HI_REGS = 4
) (
  input  logic [IDX_W-1:0] idx,
  input  logic [1:0]       width,
  input  logic             hi,
  output acc_req_t         req
);
  acc_width_e w;
  logic       byte_hi_req;
  logic       no_upper_view;

  always_comb begin
    w             = acc_width_e'(width);
    byte_hi_req   = (w == ACC_W8) && hi;
    no_upper_view = (32'(idx) >= HI_REGS);
    req.width     = w;
    req.upper     = byte_hi_req;
    req.legal     = (w != ACC_RSVD) && !(byte_hi_req && no_upper_view);
  end
endmodule

// File: rtl/rf_read_port.sv
module rf_read_port
  import rf_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 8,
  parameter int IDX_W    = 3
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic [NUM_REGS-1:0][DATA_W-1:0]  regs,
  input  logic [IDX_W-1:0]                 idx,
  input  acc_req_t                         req,
  output logic [DATA_W-1:0]                data
);
  function automatic logic [DATA_W-1:0] pick_field(input logic [DATA_W-1:0] word,
                                                   input acc_req_t r);
    logic [DATA_W-1:0] v;
    v = '0;
    if (r.legal) begin
      case (r.width)
        ACC_W32: v = word;
        ACC_W16: v = DATA_W'(word[15:0]);
        ACC_W8:  v = r.upper ? DATA_W'(word[15:8]) : DATA_W'(word[7:0]);
        default: v = '0;
      endcase
    end
    return v;
  endfunction

  logic [DATA_W-1:0] sel_word;

  always_comb begin
    sel_word = regs[idx];
    data     = pick_field(sel_word, req);
  end

  // R6
  illegal_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !req.legal |-> data == '0);

  // R4
  byte_read_pad_chk: assert property (@(posedge clk) disable iff (rst)
    (req.legal && req.width == ACC_W8) |-> data[DATA_W-1:8] == '0);
endmodule

// File: rtl/rf_write_merge.sv
module rf_write_merge
  import rf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] old_word,
  input  logic [DATA_W-1:0] wdata,
  input  acc_req_t          req,
  output logic [DATA_W-1:0] merged
);
  function automatic logic [DATA_W-1:0] fold_in(input logic [DATA_W-1:0] o,
                                                 input logic [DATA_W-1:0] d,
                                                 input acc_req_t r);
    logic [DATA_W-1:0] v;
    v = o;
    case (r.width)
      ACC_W32: v = d;
      ACC_W16: v[15:0] = d[15:0];
      ACC_W8:  if (r.upper) v[15:8] = d[7:0];
               else         v[7:0]  = d[7:0];
      default: v = o;
    endcase
    return v;
  endfunction

  always_comb merged = fold_in(old_word, wdata, req);
endmodule

// File: rtl/partial_rf.sv
module partial_rf
  import rf_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 8,
  parameter int HI_REGS  = 4,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  rd0_idx,
  input  logic [1:0]        rd0_width,
  input  logic              rd0_hi,
  output logic [DATA_W-1:0] rd0_data,
  output logic              rd0_bad,
  input  logic [IDX_W-1:0]  rd1_idx,
  input  logic [1:0]        rd1_width,
  input  logic              rd1_hi,
  output logic [DATA_W-1:0] rd1_data,
  output logic              rd1_bad,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [1:0]        wr_width,
  input  logic              wr_hi,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_bad
);
  localparam int NUM_RD = 2;

  logic [NUM_REGS-1:0][DATA_W-1:0] regs;

  logic [NUM_RD-1:0][IDX_W-1:0]  rp_idx;
  logic [NUM_RD-1:0][1:0]        rp_width;
  logic [NUM_RD-1:0]             rp_hi;
  logic [NUM_RD-1:0][DATA_W-1:0] rp_data;
  acc_req_t                      rp_req [NUM_RD];

  assign rp_idx   = {rd1_idx, rd0_idx};
  assign rp_width = {rd1_width, rd0_width};
  assign rp_hi    = {rd1_hi, rd0_hi};

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
    rf_access_decode #(.IDX_W(IDX_W), .HI_REGS(HI_REGS)) u_dec (
      .idx(rp_idx[p]), .width(rp_width[p]), .hi(rp_hi[p]), .req(rp_req[p]));
    rf_read_port #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_rd (
      .clk(clk), .rst(rst), .regs(regs), .idx(rp_idx[p]),
      .req(rp_req[p]), .data(rp_data[p]));
  end

  assign rd0_data = rp_data[0];
  assign rd1_data = rp_data[1];
  assign rd0_bad  = !rp_req[0].legal;
  assign rd1_bad  = !rp_req[1].legal;

  // write path
  acc_req_t          wr_req;
  logic [DATA_W-1:0] wr_old;
  logic [DATA_W-1:0] wr_merged;
  logic              wr_commit;

  rf_access_decode #(.IDX_W(IDX_W), .HI_REGS(HI_REGS)) u_wdec (
    .idx(wr_idx), .width(wr_width), .hi(wr_hi), .req(wr_req));

  assign wr_old    = regs[wr_idx];
  assign wr_commit = wr_en && wr_req.legal;
  assign wr_bad    = !wr_req.legal;

  rf_write_merge #(.DATA_W(DATA_W)) u_merge (
    .old_word(wr_old), .wdata(wr_data), .req(wr_req), .merged(wr_merged));

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)
        regs[i] <= '0;
      else if (wr_commit && (wr_idx == IDX_W'(i)))
        regs[i] <= wr_merged;
    end
  end

  // R9 (also covers suppressed writes of R6 and R7)
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_commit |=> regs == $past(regs));

  // R3
  half_upper_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_commit && wr_req.width == ACC_W16) |=>
      regs[$past(wr_idx)][DATA_W-1:16] == $past(wr_old[DATA_W-1:16]));

  // R5
  upper_byte_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_commit && wr_req.upper) |=>
      (regs[$past(wr_idx)][7:0] == $past(wr_old[7:0])) &&
      (regs[$past(wr_idx)][15:8] == $past(wr_data[7:0])));

  // R6
  upper_view_legal_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_req.upper && (32'(wr_idx) >= HI_REGS)) |-> wr_bad);

  // R2
  full_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_commit && wr_req.width == ACC_W32) |=> regs[$past(wr_idx)] == $past(wr_data));
endmodule

// File: tb/sim_partial_rf.sv
`timescale 1ns/100ps
module sim_partial_rf;
  logic        clk = 0;
  logic        rst = 1;
  logic [2:0]  rd0_idx = 0, rd1_idx = 0, wr_idx = 0;
  logic [1:0]  rd0_width = 0, rd1_width = 0, wr_width = 0;
  logic        rd0_hi = 0, rd1_hi = 0, wr_hi = 0, wr_en = 0;
  logic [31:0] wr_data = 0;
  logic [31:0] rd0_data, rd1_data;
  logic        rd0_bad, rd1_bad, wr_bad;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [31:0] model [8];

  always #2.5 clk = ~clk;

  partial_rf u0 (
    .clk(clk), .rst(rst),
    .rd0_idx(rd0_idx), .rd0_width(rd0_width), .rd0_hi(rd0_hi),
    .rd0_data(rd0_data), .rd0_bad(rd0_bad),
    .rd1_idx(rd1_idx), .rd1_width(rd1_width), .rd1_hi(rd1_hi),
    .rd1_data(rd1_data), .rd1_bad(rd1_bad),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_width(wr_width), .wr_hi(wr_hi),
    .wr_data(wr_data), .wr_bad(wr_bad));

  function automatic bit is_bad(int idx, int w, bit hi);
    if (w == 3) return 1;
    if (w == 2 && hi && idx > 3) return 1;
    return 0;
  endfunction

  function automatic logic [31:0] read_ref(int idx, int w, bit hi);
    longint v;
    v = model[idx];
    if (is_bad(idx, w, hi)) return 0;
    if (w == 0) return v;
    if (w == 1) return v % 65536;
    if (hi) return (v / 256) % 256;
    return v % 256;
  endfunction

  function automatic logic [31:0] write_ref(logic [31:0] old, logic [31:0] d, int w, bit hi);
    longint o, lo16, b0, b1;
    o = old;
    lo16 = o % 65536;
    b0 = o % 256;
    b1 = lo16 / 256;
    if (w == 0) return d;
    if (w == 1) return o - lo16 + (d % 65536);
    if (hi) return o - b1 * 256 + (d % 256) * 256;
    return o - b0 + (d % 256);
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // one clock: drive after negedge, compare mid-phase, update model on the edge
  task automatic step(string req, int r0, int w0, bit h0, int r1, int w1, bit h1,
                      bit we, int wi, int ww, bit wh, logic [31:0] wd);
    rd0_idx = 3'(r0); rd0_width = 2'(w0); rd0_hi = h0;
    rd1_idx = 3'(r1); rd1_width = 2'(w1); rd1_hi = h1;
    wr_en = we; wr_idx = 3'(wi); wr_width = 2'(ww); wr_hi = wh; wr_data = wd;
    #1;
    check(req, "rd0_data", rd0_data, read_ref(r0, w0, h0));
    check(req, "rd1_data", rd1_data, read_ref(r1, w1, h1));
    check(req, "rd0_bad", 32'(rd0_bad), 32'(is_bad(r0, w0, h0)));
    check(req, "rd1_bad", 32'(rd1_bad), 32'(is_bad(r1, w1, h1)));
    check(req, "wr_bad", 32'(wr_bad), 32'(is_bad(wi, ww, wh)));
    @(posedge clk);
    if (we && !is_bad(wi, ww, wh)) model[wi] = write_ref(model[wi], wd, ww, wh);
    @(negedge clk);
  endtask

  task automatic sweep(string req);
    for (int i = 0; i < 8; i += 2) step(req, i, 0, 0, i + 1, 0, 0, 0, 0, 0, 0, 32'h0);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) model[i] = 32'hDEAD_BEEF;
    // dirty the registers, then reset
    rst = 0;
    @(negedge clk);
    wr_en = 1; wr_width = 0; wr_hi = 0;
    for (int i = 0; i < 8; i++) begin wr_idx = 3'(i); wr_data = 32'hDEAD_BEEF; @(negedge clk); end
    wr_en = 0;
    rst = 1;
    @(negedge clk); @(negedge clk);
    rst = 0;
    for (int i = 0; i < 8; i++) model[i] = 0;
    sweep("R1");

    // R2 full writes to every register
    for (int i = 0; i < 8; i++) step("R2", 0, 0, 0, 1, 0, 0, 1, i, 0, 0, 32'h1111_1111 * (i + 1) + 32'h0102_0304);
    sweep("R2");

    // R3 half-word write and reads
    step("R3", 5, 1, 0, 5, 0, 0, 1, 5, 1, 0, 32'hABCD_1234);
    step("R3", 5, 1, 0, 5, 0, 0, 0, 0, 0, 0, 32'h0);

    // R4 low byte on upper-group and lower-group registers
    step("R4", 6, 2, 0, 6, 0, 0, 1, 6, 2, 0, 32'hFFFF_FF5A);
    step("R4", 6, 2, 0, 6, 0, 0, 1, 1, 2, 0, 32'h0000_00C3);
    step("R4", 1, 2, 0, 1, 0, 0, 0, 0, 0, 0, 32'h0);

    // R5 high byte on registers 0..3
    step("R5", 2, 2, 1, 2, 0, 0, 1, 2, 2, 1, 32'h1234_5677);
    step("R5", 2, 2, 1, 2, 0, 0, 1, 3, 2, 1, 32'h0000_00E1);
    step("R5", 3, 2, 1, 3, 0, 0, 0, 0, 0, 0, 32'h0);

    // R6 high byte on registers 4..7: flagged, suppressed, reads zero
    for (int i = 4; i < 8; i++) step("R6", i, 2, 1, i, 0, 0, 1, i, 2, 1, 32'hFFFF_FFFF);
    sweep("R6");

    // R7 reserved width code
    step("R7", 0, 3, 0, 4, 3, 1, 1, 0, 3, 0, 32'h7777_7777);
    step("R7", 0, 0, 0, 4, 0, 0, 1, 4, 3, 1, 32'h7777_7777);
    sweep("R7");

    // R8 read-during-write returns old, new visible next cycle
    step("R8", 1, 0, 0, 1, 1, 0, 1, 1, 0, 0, 32'hCAFE_F00D);
    step("R8", 1, 0, 0, 1, 2, 0, 1, 1, 1, 0, 32'h0000_BEEF);
    step("R8", 1, 0, 0, 1, 2, 1, 0, 0, 0, 0, 32'h0);

    // R9 write enable low
    step("R9", 7, 0, 0, 0, 0, 0, 0, 7, 0, 0, 32'h5555_AAAA);
    step("R9", 7, 0, 0, 0, 0, 0, 0, 0, 2, 1, 32'h5555_AAAA);
    sweep("R9");

    // R10 high select ignored at 32 and 16 bits
    step("R10", 7, 1, 1, 5, 0, 1, 1, 7, 1, 1, 32'h0000_9876);
    step("R10", 7, 1, 1, 7, 0, 1, 1, 6, 0, 1, 32'h0BAD_CAFE);
    sweep("R10");

    // mixed random traffic (R2..R10)
    for (int n = 0; n < 600; n++) begin
      step("R8", int'($urandom % 8), int'($urandom % 4), 1'($urandom),
           int'($urandom % 8), int'($urandom % 4), 1'($urandom),
           1'($urandom), int'($urandom % 8), int'($urandom % 4), 1'($urandom), $urandom);
    end
    sweep("R3");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule